// File: doc/BRIEF.md
# Priority-based reference clock selector

This block decides which of five reference clock candidates feeds each of two independent synchronization paths. Every candidate comes with a qualification flag from an external quality monitor. For each path the block produces a registered selection index (1 to 5) and a flag that is raised when no reference is available.

Each path runs in one of two modes. In automatic mode the path looks only at qualified candidates that have a nonzero priority, and picks the candidate with the lowest priority value. In forced mode the path takes a programmed code directly and does not look at the qualification flags.

Configuration is held in a small register bank with a synchronous write and a combinational read. The two paths each have their own set of five priorities. Both sets are reached through one shared address window, and a steering bit in the control register selects which set that window reaches.

Candidate numbering is fixed, with qualification bit i belonging to candidate i+1:

| Candidate | Signal type | Qualification bit |
|---|---|---|
| 1 | single-ended | 0 |
| 2 | differential | 1 |
| 3 | single-ended | 2 |
| 4 | differential | 3 |
| 5 | single-ended | 4 |

Top module: `refclk_selector`

## Requirements
- R1: The register map is as follows. Writes and reads of the mapped addresses store and return these fields.
  - Address 0 is control: bit 0 is the steering bit, bit 1 is the path 0 mode and bit 2 is the path 1 mode (mode 1 = forced, 0 = automatic).
  - Address 1 holds the forced codes: bits 3:0 for path 0 and bits 7:4 for path 1.
  - Addresses 2 to 6 hold the 4-bit priorities of candidates 1 to 5, in bits 3:0.
- R2: Reads and writes at addresses 2 to 6 reach the path 0 priority set when the steering bit is 0, and the path 1 set when it is 1. The other set is left unchanged.
- R3: In forced mode, a code from 1 to 5 is output as the selection index with the none flag low, whatever the qualification flags are.
- R4: In forced mode, a code of 0 or a code above 5 gives selection index 0 with the none flag high.
- R5: In automatic mode, the path selects the qualified candidate with the smallest nonzero priority value.
- R6: A priority value of 0 excludes the candidate from automatic selection, even when the candidate is qualified.
- R7: When several qualified, enabled candidates share the best priority value, the one with the lowest index is selected.
- R8: In automatic mode, if no candidate is both qualified and enabled, the selection index is 0 and the none flag is high.
- R9: The outputs are registered. A change in the qualification flags or in a register shows at the outputs one clock edge after the change is seen at an edge.
- R10: Synchronous reset sets the following:
  - the steering bit to 0;
  - both paths to automatic mode;
  - all priorities and forced codes to 0;
  - the outputs to index 0 with the none flag high.
- R11: Writes to addresses 7 to 15 change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| ref_ok | input | 5 | Qualification flags; bit i belongs to candidate i+1 |
| sel_idx | output | 2x3 | Selected candidate per path; 0 means none |
| sel_none | output | 2 | No valid reference, per path |

## Verification
Automatic selection is driven with five kinds of qualification pattern:
- all candidates qualified, which shows that the lowest priority value wins;
- the winner removed, which exposes the index tie-break between equal priorities;
- only a candidate whose priority is 0 left qualified, which separates disabled from enabled;
- no candidate qualified at all;
- patterns applied while the two paths hold different priority sets, which shows the steering keeps the sets apart.

Forced mode is tried with valid codes while no candidate is qualified, and with the out-of-range codes 0 and 7. Each pattern is compared with a behavioural reference on every clock, which also checks the one-cycle latency.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int NUM_IN    = 5;
    localparam int NUM_PATH  = 2;
    localparam int PRI_W     = 4;
    localparam int CODE_W    = 4;
    localparam int IDX_W     = $clog2(NUM_IN + 1);
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_FORCE = 1;
    localparam int ADDR_PRI0  = 2;

    typedef enum logic {MODE_AUTO = 1'b0, MODE_FORCED = 1'b1} mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             none;
    } pick_t;

    function automatic pick_t forced_pick(logic [CODE_W-1:0] code);
        pick_t r;
        if (code != '0 && int'(code) <= NUM_IN) begin
            r.idx  = IDX_W'(code);
            r.none = 1'b0;
        end else begin
            r.idx  = '0;
            r.none = 1'b1;
        end
        return r;
    endfunction

    function automatic pick_t auto_pick(logic [NUM_IN-1:0] q,
                                        logic [NUM_IN*PRI_W-1:0] pri);
        pick_t r;
        logic [PRI_W-1:0] best;
        logic [PRI_W-1:0] cur;
        r.idx  = '0;
        r.none = 1'b1;
        best   = '1;
        for (int i = 0; i < NUM_IN; i++) begin
            cur = pri[i*PRI_W +: PRI_W];
            if (q[i] && cur != '0 && (r.none || cur < best)) begin
                r.idx  = IDX_W'(i + 1);
                r.none = 1'b0;
                best   = cur;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/refsel_regbank.sv
module refsel_regbank
    import refsel_pkg::*;
#(
    parameter int N_IN   = NUM_IN,
    parameter int N_PATH = NUM_PATH,
    parameter int PW     = PRI_W,
    parameter int CW     = CODE_W,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [DW-1:0]                  wdata,
    output logic [DW-1:0]                  rdata,
    output mode_e [N_PATH-1:0]             mode_o,
    output logic [N_PATH-1:0][CW-1:0]      code_o,
    output logic [N_PATH-1:0][N_IN*PW-1:0] pri_o
);
    logic                           steer_q;
    mode_e [N_PATH-1:0]             mode_q;
    logic [N_PATH-1:0][CW-1:0]      code_q;
    logic [N_PATH-1:0][N_IN*PW-1:0] pri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            steer_q <= 1'b0;
            mode_q  <= {N_PATH{MODE_AUTO}};
            code_q  <= '0;
            pri_q   <= '0;
        end else if (we) begin
            if (addr == AW'(ADDR_CTRL)) begin
                steer_q <= wdata[0];
                for (int p = 0; p < N_PATH; p++)
                    mode_q[p] <= mode_e'(wdata[1+p]);
            end
            if (addr == AW'(ADDR_FORCE)) begin
                for (int p = 0; p < N_PATH; p++)
                    code_q[p] <= wdata[p*CW +: CW];
            end
            for (int i = 0; i < N_IN; i++) begin
                if (addr == AW'(ADDR_PRI0 + i))
                    pri_q[steer_q][i*PW +: PW] <= wdata[PW-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_CTRL)) begin
            rdata[0] = steer_q;
            for (int p = 0; p < N_PATH; p++)
                rdata[1+p] = mode_q[p];
        end
        if (addr == AW'(ADDR_FORCE)) begin
            for (int p = 0; p < N_PATH; p++)
                rdata[p*CW +: CW] = code_q[p];
        end
        for (int i = 0; i < N_IN; i++) begin
            if (addr == AW'(ADDR_PRI0 + i))
                rdata[PW-1:0] = pri_q[steer_q][i*PW +: PW];
        end
    end

    assign mode_o = mode_q;
    assign code_o = code_q;
    assign pri_o  = pri_q;

    // R10: defaults right after reset
    assert_reset_defaults_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (steer_q == 1'b0 && mode_q == '0 && pri_q == '0 && code_q == '0));

    // R11: unmapped writes leave the bank untouched
    assert_unmapped_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (we && int'(addr) >= ADDR_PRI0 + N_IN) |=>
            ($stable(steer_q) && $stable(mode_q) && $stable(code_q) && $stable(pri_q)));

    // R2: a window write leaves the non-steered set unchanged
    assert_steer_isolation_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !steer_q && int'(addr) >= ADDR_PRI0) |=> $stable(pri_q[1]));
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
    import refsel_pkg::*;
#(
    parameter int N_IN = NUM_IN,
    parameter int PW   = PRI_W,
    parameter int CW   = CODE_W,
    parameter int IW   = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mode_e                mode_i,
    input  logic [CW-1:0]        code_i,
    input  logic [N_IN*PW-1:0]   pri_i,
    input  logic [N_IN-1:0]      qual_i,
    output logic [IW-1:0]        idx_o,
    output logic                 none_o
);
    pick_t nxt;

    always_comb begin
        if (mode_i == MODE_FORCED) nxt = forced_pick(code_i);
        else                       nxt = auto_pick(qual_i, pri_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o  <= '0;
            none_o <= 1'b1;
        end else begin
            idx_o  <= nxt.idx;
            none_o <= nxt.none;
        end
    end

    // R8: none flag always pairs with index 0, and a nonzero index with a low flag
    assert_none_zero_idx_R8: assert property (@(posedge clk) disable iff (rst)
        none_o == (idx_o == '0));

    // R3: valid forced code appears one cycle later
    assert_forced_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_FORCED && code_i != '0 && int'(code_i) <= N_IN)
            |=> (!none_o && int'(idx_o) == int'($past(code_i))));

    // R4: invalid forced code gives none
    assert_forced_bad_code_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_FORCED && (code_i == '0 || int'(code_i) > N_IN)) |=> none_o);

    // R5: automatic choice was qualified one cycle before
    assert_auto_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_AUTO) |=>
            (none_o || ((($past(qual_i) >> (idx_o - IW'(1))) & N_IN'(1)) != '0)));
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refsel_pkg::*;
#(
    parameter int N_IN   = NUM_IN,
    parameter int N_PATH = NUM_PATH,
    parameter int PW     = PRI_W,
    parameter int CW     = CODE_W,
    parameter int IW     = IDX_W,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [AW-1:0]              cfg_addr,
    input  logic [DW-1:0]              cfg_wdata,
    output logic [DW-1:0]              cfg_rdata,
    input  logic [N_IN-1:0]            ref_ok,
    output logic [N_PATH-1:0][IW-1:0]  sel_idx,
    output logic [N_PATH-1:0]          sel_none
);
    mode_e [N_PATH-1:0]             mode_w;
    logic [N_PATH-1:0][CW-1:0]      code_w;
    logic [N_PATH-1:0][N_IN*PW-1:0] pri_w;

    refsel_regbank #(
        .N_IN(N_IN), .N_PATH(N_PATH), .PW(PW), .CW(CW), .AW(AW), .DW(DW)
    ) bank_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .mode_o(mode_w), .code_o(code_w), .pri_o(pri_w)
    );

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        refsel_pick #(.N_IN(N_IN), .PW(PW), .CW(CW), .IW(IW)) pick_i (
            .clk(clk), .rst(rst), .mode_i(mode_w[p]), .code_i(code_w[p]),
            .pri_i(pri_w[p]), .qual_i(ref_ok),
            .idx_o(sel_idx[p]), .none_o(sel_none[p])
        );
    end
endmodule

// File: tb/refclk_selector_tb.sv
module refclk_selector_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [4:0] ref_ok = '0;
    logic [1:0][2:0] sel_idx;
    logic [1:0]      sel_none;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R10";
    bit done = 0;

    // reference model state
    int m_steer;
    int m_mode [2];
    int m_code [2];
    int m_pri  [2][5];
    int exp_idx [2];

    always #4 clk = ~clk;   // 125 MHz

    refclk_selector dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ref_ok(ref_ok),
        .sel_idx(sel_idx), .sel_none(sel_none)
    );

    function automatic int ref_choice(int p);
        if (m_mode[p] != 0)
            return (m_code[p] >= 1 && m_code[p] <= 5) ? m_code[p] : 0;
        for (int lvl = 1; lvl < 16; lvl++)
            for (int n = 1; n <= 5; n++)
                if (ref_ok[n-1] && m_pri[p][n-1] == lvl) return n;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_steer = 0;
            for (int p = 0; p < 2; p++) begin
                m_mode[p] = 0; m_code[p] = 0; exp_idx[p] = 0;
                for (int n = 0; n < 5; n++) m_pri[p][n] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) exp_idx[p] = ref_choice(p);
            if (cfg_we) begin
                case (int'(cfg_addr))
                    0: begin
                        m_steer = int'(cfg_wdata[0]);
                        m_mode[0] = int'(cfg_wdata[1]);
                        m_mode[1] = int'(cfg_wdata[2]);
                    end
                    1: begin
                        m_code[0] = int'(cfg_wdata[3:0]);
                        m_code[1] = int'(cfg_wdata[7:4]);
                    end
                    2, 3, 4, 5, 6: m_pri[m_steer][int'(cfg_addr) - 2] = int'(cfg_wdata[3:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // per-clock comparison against the model (covers R9 latency)
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int p = 0; p < 2; p++) begin
                check(cur_req, int'(sel_idx[p]), exp_idx[p]);
                check(cur_req, int'(sel_none[p]), exp_idx[p] == 0 ? 1 : 0);
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(string req, int a, int expv);
        @(negedge clk);
        cfg_addr = 4'(a);
        #1;
        check(req, int'(cfg_rdata), expv);
    endtask

    task automatic set_ok(int q, int cycles);
        @(negedge clk);
        ref_ok = 5'(q);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        cur_req = "R10";
        check("R10", int'(sel_none), 3);
        check("R10", int'(sel_idx), 0);
        rd_check("R10", 0, 0);
        rd_check("R10", 1, 0);
        rd_check("R10", 4, 0);

        // R1 control and forced-code fields
        cur_req = "R1";
        wr(1, 8'hA3);
        rd_check("R1", 1, 8'hA3);
        wr(0, 8'h00);
        rd_check("R1", 0, 0);

        // R2 priority sets, steered
        cur_req = "R2";
        wr(2, 3); wr(3, 2); wr(4, 2); wr(5, 0); wr(6, 1);
        wr(0, 1);
        wr(2, 5); wr(3, 5); wr(4, 5); wr(5, 5); wr(6, 5);
        rd_check("R2", 2, 5);
        rd_check("R2", 6, 5);
        wr(0, 0);
        rd_check("R2", 2, 3);
        rd_check("R2", 6, 1);
        rd_check("R2", 5, 0);

        // R5 / R7 all qualified: path0 -> 5, path1 tie -> 1
        cur_req = "R5";
        set_ok(5'b11111, 3);
        check("R5", int'(sel_idx[0]), 5);
        check("R7", int'(sel_idx[1]), 1);
        // R7 tie between 2 and 3 on path0
        cur_req = "R7";
        set_ok(5'b01111, 3);
        check("R7", int'(sel_idx[0]), 2);
        // R6 only candidate 4 (priority 0 on path0)
        cur_req = "R6";
        set_ok(5'b01000, 3);
        check("R6", int'(sel_none[0]), 1);
        check("R6", int'(sel_idx[1]), 4);
        // R8 nothing qualified
        cur_req = "R8";
        set_ok(5'b00000, 3);
        check("R8", int'(sel_none), 3);
        // R9 latency: toggles every cycle, compared each clock
        cur_req = "R9";
        for (int k = 0; k < 8; k++) set_ok((k * 7) % 32, 1);

        // R3 forced, nothing qualified
        cur_req = "R3";
        set_ok(0, 1);
        wr(1, 8'h53);
        wr(0, 6);
        repeat (2) @(negedge clk);
        check("R3", int'(sel_idx[0]), 3);
        check("R3", int'(sel_idx[1]), 5);
        set_ok(5'b11111, 3);
        check("R3", int'(sel_idx[0]), 3);
        // R4 invalid codes 0 and 7
        cur_req = "R4";
        wr(1, 8'h70);
        repeat (2) @(negedge clk);
        check("R4", int'(sel_none), 3);
        // back to auto on path0 only
        cur_req = "R5";
        wr(0, 4);
        repeat (2) @(negedge clk);
        check("R5", int'(sel_idx[0]), 5);

        // R11 unmapped address
        cur_req = "R11";
        wr(9, 8'hFF);
        wr(15, 8'hFF);
        rd_check("R11", 9, 0);
        rd_check("R11", 0, 4);
        rd_check("R11", 6, 1);
        repeat (3) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule